// File: doc/BRIEF.md
# Indirect Accelerator Descriptor Window

This block answers host register accesses for a capability that exposes a read-only descriptor for each accelerator behind one function. The host cannot address the descriptor directly. It picks an accelerator with an index select register. It writes a byte offset into a window offset register, then polls that register's top bit until the block marks the word ready. Finally it reads the 32-bit word from a window data register.

Descriptor contents are constant and come from a computed lookup. Each fetch takes a programmable number of cycles. A bit mask selects which of the 64 possible indices hold an accelerator. Every other index is a hole that returns zeros.

The host side is a plain word-addressed register port. A write takes effect at the clock edge where `reg_we` is high. Read data is registered: it reflects the addressed register as it stood just before the edge that captures `reg_addr`.

Top module: `afu_desc_window`

## Requirements
- R1: After synchronous reset, every register reads 0 and the ready flag is 0.
- R2: Word address 0 is the index select: bits 5:0 are writable and read back, and bits 31:6 read 0. Address 1 is the offset/status register. Address 2 is the data register, and writes to it are ignored. Address 3 reads 0 and ignores writes.
- R3: A write to address 1 clears the ready flag in bit 31 at that edge. The flag stays 0 for FETCH_LAT clock edges and then reads 1.
- R4: Bit 31 of a value written to address 1 is ignored. The stored offset is bits 30:0, and it reads back in bits 30:0.
- R5: A write to address 1 while a fetch is pending restarts the latency count, and the word returned is the one for the latest offset.
- R6: A write to address 0 clears the ready flag and cancels any pending fetch. The flag stays 0 until the next write to address 1.
- R7: For a present index, byte offset 0 returns {length[31:16], major[15:8], minor[7:0]}. Even indices carry version 1.1 with length 0x60 (0x00600101). Odd indices carry version 1.0 with length 0x58 (0x00580100).
- R8: Offsets 0x4 + 4k for k = 0..5 return name word k = {0x30+k, 0x5F, 0x41+idx, 0x61+idx}, most significant byte first.
- R9: Offset 0x1C returns major = idx+1 in [31:24], minor = 2*idx in [23:16], type A = idx[1:0] in [15:14], type B = ~idx[1:0] in [13:12], zeros in [11:8], and profile = 0xA0+idx in [7:0].
- R10: Other word offsets below the length return {idx zero-extended to 8 bits, 0xC3, 0x00, word number}. Offset bits 1:0 are ignored.
- R11: Any offset at or above the index's template length returns 0.
- R12: An index whose bit in PRESENT_MASK is clear returns 0 at every offset. The default mask makes indices 0, 1 and 3 present.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 2 | Word address of the register accessed |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data for the previous cycle's address |

## Verification
The bench counts the ready flag edge by edge after an offset write. A design whose latency is off by one shows the flag one poll early or one poll late.

A second offset write is issued mid-fetch. A design that ignores the restart raises the flag at the first write's deadline and returns the first word.

An index write lands mid-fetch. A design that does not cancel reports ready with a word from the old index.

The bench also reads the last word below each template length, the first word at or above it, an unaligned offset, and hole indices both in the middle of the map and at its top. These catch comparisons that use the wrong length, low offset bits that leak into the lookup, and holes that return populated contents.

// File: rtl/afu_desc_pkg.sv
package afu_desc_pkg;

  typedef enum logic [1:0] {
    RA_SELECT = 2'd0,
    RA_WINOFS = 2'd1,
    RA_WINDAT = 2'd2,
    RA_RSVD   = 2'd3
  } reg_addr_e;

  localparam logic [15:0] LEN_V10 = 16'h0058;
  localparam logic [15:0] LEN_V11 = 16'h0060;

  // Constant descriptor content for one accelerator at one byte offset.
  function automatic logic [31:0] desc_word(input logic [7:0] idx,
                                            input logic [30:0] ofs,
                                            input logic present);
    logic [15:0] len;
    logic [30:0] base;
    logic [4:0]  widx;
    logic [7:0]  k;
    logic [31:0] w;
    len  = idx[0] ? LEN_V10 : LEN_V11;
    base = {ofs[30:2], 2'b00};
    widx = ofs[6:2];
    k    = 8'(widx) - 8'd1;
    w    = '0;
    if (present && (base < 31'(len))) begin
      case (widx)
        5'd0: w = {len, 8'h01, (idx[0] ? 8'h00 : 8'h01)};
        5'd1, 5'd2, 5'd3, 5'd4, 5'd5, 5'd6:
          w = {8'h30 + k, 8'h5F, 8'h41 + idx, 8'h61 + idx};
        5'd7: w = {idx + 8'd1, {idx[6:0], 1'b0}, idx[1:0], ~idx[1:0],
                   4'h0, 8'hA0 + idx};
        default: w = {idx, 8'hC3, 8'h00, 3'b000, widx};
      endcase
    end
    return w;
  endfunction

endpackage

// File: rtl/afu_desc_rom.sv
module afu_desc_rom
  import afu_desc_pkg::*;
#(
  parameter int IDX_W = 6,
  parameter logic [(1<<IDX_W)-1:0] PRESENT_MASK = 64'h0000_0000_0000_000B
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] idx,
  input  logic [30:0]      ofs,
  output logic [31:0]      word_q
);
  logic present;
  assign present = PRESENT_MASK[idx];

  // Registered lookup: a constant table read with an output register.
  always_ff @(posedge clk) begin
    if (rst) word_q <= '0;
    else     word_q <= desc_word(8'(idx), ofs, present);
  end
endmodule

// File: rtl/afu_fetch_timer.sv
module afu_fetch_timer #(
  parameter int LAT = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic cancel,
  output logic valid,
  output logic done
);
  localparam int CW = $clog2(LAT + 1);
  localparam logic [CW-1:0] LOAD = CW'(LAT);

  logic [CW-1:0] cnt_q;

  assign done = (cnt_q == CW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      valid <= 1'b0;
    end else if (start) begin
      cnt_q <= LOAD;
      valid <= 1'b0;
    end else if (cancel) begin
      cnt_q <= '0;
      valid <= 1'b0;
    end else if (done) begin
      cnt_q <= '0;
      valid <= 1'b1;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - CW'(1);
    end
  end
endmodule

// File: rtl/afu_desc_window.sv
module afu_desc_window
  import afu_desc_pkg::*;
#(
  parameter int IDX_W     = 6,
  parameter int FETCH_LAT = 4,   // must be at least 2 (lookup is registered)
  parameter logic [(1<<IDX_W)-1:0] PRESENT_MASK = 64'h0000_0000_0000_000B
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [1:0]  reg_addr,
  input  logic        reg_we,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata
);
  localparam int PAD_W = 32 - IDX_W;

  logic [IDX_W-1:0] idx_q;
  logic [30:0]      ofs_q;
  logic [31:0]      data_q;
  logic [31:0]      rom_word;
  logic             wr_sel, wr_ofs;
  logic             fetch_valid, fetch_done;

  assign wr_sel = reg_we && (reg_addr == RA_SELECT);
  assign wr_ofs = reg_we && (reg_addr == RA_WINOFS);

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q <= '0;
      ofs_q <= '0;
    end else begin
      if (wr_sel) idx_q <= reg_wdata[IDX_W-1:0];
      if (wr_ofs) ofs_q <= reg_wdata[30:0];
    end
  end

  afu_desc_rom #(
    .IDX_W(IDX_W),
    .PRESENT_MASK(PRESENT_MASK)
  ) u_rom (
    .clk(clk),
    .rst(rst),
    .idx(idx_q),
    .ofs(ofs_q),
    .word_q(rom_word)
  );

  afu_fetch_timer #(
    .LAT(FETCH_LAT)
  ) u_timer (
    .clk(clk),
    .rst(rst),
    .start(wr_ofs),
    .cancel(wr_sel),
    .valid(fetch_valid),
    .done(fetch_done)
  );

  always_ff @(posedge clk) begin
    if (rst)             data_q <= '0;
    else if (fetch_done) data_q <= rom_word;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else begin
      case (reg_addr)
        RA_SELECT: reg_rdata <= {{PAD_W{1'b0}}, idx_q};
        RA_WINOFS: reg_rdata <= {fetch_valid, ofs_q};
        RA_WINDAT: reg_rdata <= data_q;
        default:   reg_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/afu_desc_window_chk.sv
module afu_desc_window_chk #(
  parameter int IDX_W = 6,
  parameter logic [(1<<IDX_W)-1:0] PRESENT_MASK = 64'h0000_0000_0000_000B
) (
  input logic             clk,
  input logic             rst,
  input logic [1:0]       reg_addr,
  input logic             reg_we,
  input logic [31:0]      reg_rdata,
  input logic             fetch_valid,
  input logic             fetch_done,
  input logic [IDX_W-1:0] idx_q,
  input logic [31:0]      data_q
);
  p_ofs_wr_clears_valid_r3: assert property (@(posedge clk) disable iff (rst)
    (reg_we && reg_addr == 2'd1) |=> !fetch_valid);

  p_sel_wr_clears_valid_r6: assert property (@(posedge clk) disable iff (rst)
    (reg_we && reg_addr == 2'd0) |=> !fetch_valid);

  p_valid_from_timer_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(fetch_valid) |-> $past(fetch_done));

  p_data_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (fetch_valid && $past(fetch_valid)) |-> $stable(data_q));

  p_hole_zero_r12: assert property (@(posedge clk) disable iff (rst)
    ($rose(fetch_valid) && !PRESENT_MASK[idx_q]) |-> (data_q == 32'd0));

  p_sel_upper_zero_r2: assert property (@(posedge clk) disable iff (rst)
    (reg_addr == 2'd0) |=> (reg_rdata[31:IDX_W] == '0));

  p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (rst)
    (reg_addr == 2'd3) |=> (reg_rdata == 32'd0));
endmodule

bind afu_desc_window afu_desc_window_chk #(
  .IDX_W(IDX_W),
  .PRESENT_MASK(PRESENT_MASK)
) u_chk (
  .clk(clk),
  .rst(rst),
  .reg_addr(reg_addr),
  .reg_we(reg_we),
  .reg_rdata(reg_rdata),
  .fetch_valid(fetch_valid),
  .fetch_done(fetch_done),
  .idx_q(idx_q),
  .data_q(data_q)
);

// File: tb/afu_desc_window_tb.sv
module afu_desc_window_tb;
  localparam int LAT = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  reg_addr = 2'd0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;

  int checks = 0;
  int errors = 0;
  bit done_flag = 1'b0;
  bit smp = 1'b0;

  typedef struct {
    string       req;
    logic [31:0] exp;
  } item_t;
  item_t q[$];

  always #10 clk = ~clk;

  afu_desc_window #(.FETCH_LAT(LAT)) u_dut (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  // Expected descriptor content, written from the requirements.
  function automatic logic [31:0] exp_word(input int idx, input int ofs);
    int base, len, wn;
    logic [7:0] i8;
    i8 = 8'(idx);
    if (!(idx == 0 || idx == 1 || idx == 3)) return 32'h0;   // R12
    len  = (idx % 2 == 1) ? 'h58 : 'h60;
    base = ofs & ~3;
    if (base >= len) return 32'h0;                            // R11
    wn = base / 4;
    if (wn == 0) return (idx % 2 == 1) ? 32'h0058_0100 : 32'h0060_0101; // R7
    if (wn <= 6)
      return {8'(8'h30 + wn - 1), 8'h5F, 8'(8'h41 + idx), 8'(8'h61 + idx)}; // R8
    if (wn == 7)
      return {8'(idx + 1), 8'(2 * idx), i8[1:0], ~i8[1:0], 4'h0, 8'(8'hA0 + idx)}; // R9
    return {i8, 8'hC3, 8'h00, 8'(wn)};                        // R10
  endfunction

  // Monitor: pops expected items and compares them against the read data.
  always @(negedge clk) begin
    if (smp) begin
      item_t it;
      smp = 1'b0;
      it = q.pop_front();
      checks++;
      if (reg_rdata !== it.exp) begin
        errors++;
        $display("FAIL %s: got %h expected %h", it.req, reg_rdata, it.exp);
      end
    end
  end

  task automatic chk_read(input logic [1:0] a, input logic [31:0] e, input string req);
    item_t it;
    reg_addr = a;
    it.req = req;
    it.exp = e;
    q.push_back(it);
    @(posedge clk); #1;
    smp = 1'b1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    reg_addr = a; reg_we = 1'b1; reg_wdata = d;
    @(posedge clk); #1;
    reg_we = 1'b0;
  endtask

  task automatic idle();
    @(posedge clk); #1;
  endtask

  task automatic peek(input logic [1:0] a, output logic [31:0] v);
    reg_addr = a;
    @(posedge clk); #1;
    v = reg_rdata;
  endtask

  task automatic fetch(input int idx, input int ofs, input string req);
    logic [31:0] v;
    bit ok;
    wr(2'd1, 32'(ofs));
    ok = 1'b0;
    for (int n = 0; n < 64 && !ok; n++) begin
      peek(2'd1, v);
      ok = v[31];
    end
    if (!ok) begin
      checks++; errors++;
      $display("FAIL %s: ready never set, got %h expected %h", req, v, 32'h8000_0000 | ofs);
    end
    chk_read(2'd2, exp_word(idx, ofs), req);
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    // R1 reset state
    chk_read(2'd0, 32'h0, "R1");
    chk_read(2'd1, 32'h0, "R1");
    chk_read(2'd2, 32'h0, "R1");
    chk_read(2'd3, 32'h0, "R1");
    // R2 index select width and reserved word
    wr(2'd0, 32'hFFFF_FFFF);
    chk_read(2'd0, 32'h0000_003F, "R2");
    wr(2'd3, 32'hFFFF_FFFF);
    chk_read(2'd3, 32'h0, "R2");
    // R12 hole at top of map
    fetch(63, 'h1C, "R12");
    fetch(63, 'h0, "R12");
    // R3 exact latency on index 0, offset 0
    wr(2'd0, 32'd0);
    wr(2'd1, 32'h0);
    for (int k = 0; k < LAT; k++) chk_read(2'd1, 32'h0, "R3");
    chk_read(2'd1, 32'h8000_0000, "R3");
    chk_read(2'd2, exp_word(0, 0), "R7");
    // R7 R8 R10 R11 index 0
    for (int k = 0; k < 6; k++) fetch(0, 4 + 4 * k, "R8");
    fetch(0, 'h1C, "R9");
    fetch(0, 'h20, "R10");
    fetch(0, 'h23, "R10");
    fetch(0, 'h5C, "R10");
    fetch(0, 'h60, "R11");
    fetch(0, 'h1000, "R11");
    // R2 data register ignores writes
    wr(2'd2, 32'hDEAD_BEEF);
    chk_read(2'd2, exp_word(0, 'h1000), "R2");
    chk_read(2'd1, 32'h8000_1000, "R2");
    // index 1: version 1.0
    wr(2'd0, 32'd1);
    fetch(1, 'h0, "R7");
    fetch(1, 'h1C, "R9");
    fetch(1, 'h54, "R10");
    fetch(1, 'h58, "R11");
    // R12 hole in the middle
    wr(2'd0, 32'd2);
    fetch(2, 'h0, "R12");
    fetch(2, 'h4, "R12");
    // R4 bit 31 of written offset ignored
    wr(2'd0, 32'd3);
    wr(2'd1, 32'h8000_001C);
    chk_read(2'd1, 32'h0000_001C, "R4");
    fetch(3, 'h1C, "R4");
    fetch(3, 'h8, "R8");
    // R5 restart during pending fetch
    wr(2'd1, 32'h0);
    idle();
    wr(2'd1, 32'h1C);
    for (int k = 0; k < LAT; k++) chk_read(2'd1, 32'h0000_001C, "R5");
    chk_read(2'd1, 32'h8000_001C, "R5");
    chk_read(2'd2, exp_word(3, 'h1C), "R5");
    // R6 index write cancels pending fetch
    wr(2'd0, 32'd0);
    wr(2'd1, 32'h0);
    wr(2'd0, 32'd1);
    for (int k = 0; k < 2 * LAT; k++) chk_read(2'd1, 32'h0, "R6");
    chk_read(2'd2, exp_word(3, 'h1C), "R6");
    fetch(1, 'h0, "R6");
    repeat (3) idle();
    finish_run();
  end
endmodule